// File: doc/BRIEF.md
# Cache-Line Atomic Swap Unit

This block performs single-cycle atomic read-modify-write operations on a 64-byte cache line held in registers. The requester issues one strobe with a byte offset, an operand size of 4 or 8 bytes, a swap value, a compare value and a conditional flag. The unit returns the operand that was stored at that offset before the operation.

A plain swap always stores the new value. A conditional swap stores it only when the stored operand equals the compare value. For a 4-byte operand only the low half of the compare value takes part, and only the low half of the swap value is stored. An operation whose size is not 4 or 8, or whose offset is not a multiple of its size, raises an error and changes nothing.

The line register starts at zero. Its whole contents are visible on a read-only port. Requesters use plain swaps to load it and ordinary operations to inspect it. Results register on the clock edge that takes the strobe, so a following operation already sees the new contents.

Top module: `lineCasUnit`

## Requirements
- R1: After reset the line is all zero, and `oldData`, `done` and `err` are 0.
- R2: `done` is 1 for exactly the cycle after each cycle with `opValid` high, and 0 after every cycle with `opValid` low.
- R3: A plain swap (`opCond`=0) of a legal size and alignment always writes the operand. Byte k of the swap value, counting from the least significant byte, goes to line byte `opOffset`+k. Line byte n occupies `lineOut[8n+7:8n]`.
- R4: A conditional 8-byte swap writes only when all 64 bits of `opCmpData` equal the 8 stored bytes. A difference in the upper 32 bits alone is enough to block the write.
- R5: A conditional 4-byte swap compares only `opCmpData[31:0]` against the 4 stored bytes. On a 4-byte write, `opSwapData[63:32]` is ignored.
- R6: `oldData` holds the operand stored before the operation, whether or not the write took place. A 4-byte operand is zero-extended.
- R7: An `opSize` other than 4 or 8 sets `err`, leaves the line unchanged and returns `oldData` = 0.
- R8: An offset that is not a multiple of the operand size sets `err` and leaves the line unchanged. `oldData` is 0.
- R9: Line bytes outside the addressed operand are never modified, and the line does not change on cycles without an operation.
- R10: Two operations on consecutive cycles to the same offset are ordered. The second sees the result of the first in both its comparison and its `oldData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe, one operation per cycle |
| opOffset | input | 6 | Byte offset of the operand in the line |
| opSize | input | 4 | Operand size in bytes (4 or 8 are legal) |
| opCond | input | 1 | 1 = conditional swap, 0 = plain swap |
| opSwapData | input | 64 | Value to store |
| opCmpData | input | 64 | Compare value for a conditional swap |
| oldData | output | 64 | Previous operand contents, registered |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal size or alignment, valid with `done` |
| lineOut | output | 512 | Current line contents |

## Verification
Plain swaps at both widths load known patterns. Conditional swaps then run with a current compare value and a stale one, which separates a taken write from a suppressed one. One 8-byte compare differs only in its upper half, which shows the full width is used. Another 4-byte compare differs only in its upper half, which shows that half is ignored. Illegal sizes, misaligned offsets and the last word of the line probe the edges. After every operation the whole line is compared against a byte model, so stray writes to neighbouring bytes show up. A back-to-back pair to one offset checks ordering.

// File: rtl/lineCasPkg.sv
package lineCasPkg;
  // Strobes from control to datapath for the operation in the current cycle
  typedef struct packed {
    logic capture; // an operation is presented this cycle
    logic wrEn;    // store the swap operand into the line
    logic wide;    // full-width operand (else half width)
    logic errNow;  // illegal size or alignment
  } casCtl_t;
endpackage

// File: rtl/lineCasCtrl.sv
module lineCasCtrl
  import lineCasPkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          opValid,
  input  logic [$clog2(LINE_BYTES)-1:0] opOffset,
  input  logic [$clog2(WORD_BYTES):0]   opSize,
  input  logic                          opCond,
  input  logic                          cmpMatch,
  output casCtl_t                       ctl,
  output logic                          done,
  output logic                          err
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SIZE_W = $clog2(WORD_BYTES) + 1;
  localparam int HALF   = WORD_BYTES / 2;

  logic sizeWide, sizeHalf, alignOk, legal;

  always_comb begin
    sizeWide = (opSize == SIZE_W'(WORD_BYTES));
    sizeHalf = (opSize == SIZE_W'(HALF));
    if (sizeWide)
      alignOk = ((opOffset % OFF_W'(WORD_BYTES)) == '0);
    else
      alignOk = ((opOffset % OFF_W'(HALF)) == '0);
    legal = (sizeWide || sizeHalf) && alignOk;

    ctl.capture = opValid;
    ctl.wide    = sizeWide;
    ctl.errNow  = opValid && !legal;
    ctl.wrEn    = opValid && legal && (!opCond || cmpMatch);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= opValid;
      err  <= opValid && !legal;
    end
  end

  AST_DONE_AFTER_OP: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !done); // R2
  AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done); // R7
endmodule

// File: rtl/lineCasDatapath.sv
module lineCasDatapath
  import lineCasPkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  casCtl_t                       ctl,
  input  logic [$clog2(LINE_BYTES)-1:0] opOffset,
  input  logic                          opCond,
  input  logic [WORD_BYTES*8-1:0]       opSwapData,
  input  logic [WORD_BYTES*8-1:0]       opCmpData,
  output logic                          cmpMatch,
  output logic [WORD_BYTES*8-1:0]       oldData,
  output logic [LINE_BYTES*8-1:0]       lineOut
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORD_W = WORD_BYTES * 8;
  localparam int HALF_W = WORD_W / 2;
  localparam logic [OFF_W:0] WIDE_LEN = (OFF_W+1)'(WORD_BYTES);
  localparam logic [OFF_W:0] HALF_LEN = (OFF_W+1)'(WORD_BYTES / 2);

  logic [LINE_W-1:0]     lineQ, lineD, shifted, swapWide;
  logic [OFF_W+2:0]      shAmt;
  logic [WORD_W-1:0]     oldWide, oldSel, swapSel;
  logic [OFF_W:0]        opEnd;
  logic [LINE_BYTES-1:0] byteHit;

  always_comb begin
    shAmt    = {opOffset, 3'b000};
    shifted  = lineQ >> shAmt;
    oldWide  = shifted[WORD_W-1:0];
    oldSel   = ctl.wide ? oldWide : {{(WORD_W-HALF_W){1'b0}}, oldWide[HALF_W-1:0]};
    swapSel  = ctl.wide ? opSwapData : {{(WORD_W-HALF_W){1'b0}}, opSwapData[HALF_W-1:0]};
    swapWide = {{(LINE_W-WORD_W){1'b0}}, swapSel} << shAmt;
    opEnd    = {1'b0, opOffset} + (ctl.wide ? WIDE_LEN : HALF_LEN);
    cmpMatch = ctl.wide ? (oldWide == opCmpData)
                        : (oldWide[HALF_W-1:0] == opCmpData[HALF_W-1:0]);
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : gByte
    assign byteHit[b] = ctl.wrEn && ((OFF_W+1)'(b) >= {1'b0, opOffset})
                                 && ((OFF_W+1)'(b) < opEnd);
    assign lineD[8*b +: 8] = byteHit[b] ? swapWide[8*b +: 8] : lineQ[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ   <= '0;
      oldData <= '0;
    end else begin
      if (ctl.wrEn)
        lineQ <= lineD;
      if (ctl.capture)
        oldData <= ctl.errNow ? '0 : oldSel;
    end
  end

  assign lineOut = lineQ;

  AST_CMP_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture && opCond && !cmpMatch |=> $stable(lineQ)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(lineQ)); // R9
  AST_WRITE_ONE_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
    $countones(byteHit) == 0 || $countones(byteHit) == WORD_BYTES
    || $countones(byteHit) == WORD_BYTES / 2); // R9
endmodule

// File: rtl/lineCasUnit.sv
module lineCasUnit
  import lineCasPkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          opValid,
  input  logic [$clog2(LINE_BYTES)-1:0] opOffset,
  input  logic [$clog2(WORD_BYTES):0]   opSize,
  input  logic                          opCond,
  input  logic [WORD_BYTES*8-1:0]       opSwapData,
  input  logic [WORD_BYTES*8-1:0]       opCmpData,
  output logic [WORD_BYTES*8-1:0]       oldData,
  output logic                          done,
  output logic                          err,
  output logic [LINE_BYTES*8-1:0]       lineOut
);
  casCtl_t ctl;
  logic    cmpMatch;

  lineCasCtrl #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opOffset(opOffset),
    .opSize(opSize), .opCond(opCond), .cmpMatch(cmpMatch),
    .ctl(ctl), .done(done), .err(err)
  );

  lineCasDatapath #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opOffset(opOffset), .opCond(opCond),
    .opSwapData(opSwapData), .opCmpData(opCmpData), .cmpMatch(cmpMatch),
    .oldData(oldData), .lineOut(lineOut)
  );

  AST_ERR_ZERO_OLD: assert property (@(posedge clk) disable iff (!rstN)
    err |-> oldData == '0); // R7
  AST_ERR_LINE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    err |-> lineOut == $past(lineOut)); // R8
endmodule

// File: tb/sim_lineCasUnit.sv
module sim_lineCasUnit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0]  off;
    logic [3:0]  size;
    logic        cond;
    logic [63:0] swap;
    logic [63:0] cmp;
    logic [63:0] expOld;
    logic        expErr;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{6'd0,  4'd8, 1'b0, 64'h1122334455667788, 64'h0, 64'h0, 1'b0},                                // R3
    '{6'd8,  4'd4, 1'b0, 64'hAABBCCDDCAFEF00D, 64'h0, 64'h0, 1'b0},                                // R5 R9
    '{6'd0,  4'd8, 1'b1, 64'h0102030405060708, 64'h1122334455667788, 64'h1122334455667788, 1'b0},  // R4
    '{6'd0,  4'd8, 1'b1, 64'hDEADBEEF00000000, 64'hFFFFFFFF05060708, 64'h0102030405060708, 1'b0},  // R4 R6
    '{6'd8,  4'd4, 1'b1, 64'hFFFFFFFF9999AAAA, 64'h12345678CAFEF00D, 64'h00000000CAFEF00D, 1'b0},  // R5
    '{6'd8,  4'd4, 1'b1, 64'h0000000000000077, 64'h00000000CAFEF00D, 64'h000000009999AAAA, 1'b0},  // R5 R6
    '{6'd12, 4'd4, 1'b0, 64'h0000000055AA55AA, 64'h0, 64'h0, 1'b0},                                // R9
    '{6'd8,  4'd8, 1'b1, 64'h0BADF00D0BADF00D, 64'h55AA55AA9999AAAA, 64'h55AA55AA9999AAAA, 1'b0},  // R4
    '{6'd0,  4'd2, 1'b0, 64'h00000000000000EE, 64'h0, 64'h0, 1'b1},                                // R7
    '{6'd4,  4'd8, 1'b0, 64'h1111111111111111, 64'h0, 64'h0, 1'b1},                                // R8
    '{6'd2,  4'd4, 1'b1, 64'h2222222222222222, 64'h0, 64'h0, 1'b1},                                // R8
    '{6'd56, 4'd8, 1'b0, 64'hFEDCBA9876543210, 64'h0, 64'h0, 1'b0},                                // R3
    '{6'd56, 4'd8, 1'b1, 64'h0000000000000001, 64'hFEDCBA9876543210, 64'hFEDCBA9876543210, 1'b0},  // R4
    '{6'd0,  4'd0, 1'b0, 64'h3333333333333333, 64'h0, 64'h0, 1'b1}                                 // R7
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid, opCond;
  logic [5:0]  opOffset;
  logic [3:0]  opSize;
  logic [63:0] opSwapData, opCmpData, oldData;
  logic        done, err;
  logic [511:0] lineOut;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  finished = 1'b0;
  logic [7:0] mdl [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  lineCasUnit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opOffset(opOffset),
    .opSize(opSize), .opCond(opCond), .opSwapData(opSwapData),
    .opCmpData(opCmpData), .oldData(oldData), .done(done), .err(err),
    .lineOut(lineOut)
  );

  function automatic logic [63:0] mdlRead(input int off, input int len);
    logic [63:0] v = '0;
    for (int k = 0; k < len; k++) v[8*k +: 8] = mdl[off + k];
    return v;
  endfunction

  function automatic logic [511:0] mdlLine();
    logic [511:0] v;
    for (int n = 0; n < 64; n++) v[8*n +: 8] = mdl[n];
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkLine(input string req);
    logic [511:0] exp = mdlLine();
    testCnt++;
    if (lineOut !== exp) begin
      failCnt++;
      $display("FAIL %s line: actual %h expected %h", req, lineOut, exp);
    end
  endtask

  // Drive at a falling edge, check at the next one; the caller may chain ops.
  task automatic doOp(input vec_t v, input string req);
    int  off = int'(v.off);
    int  len = int'(v.size);
    bit  legal, match;
    logic [63:0] prev;
    opValid = 1'b1; opOffset = v.off; opSize = v.size; opCond = v.cond;
    opSwapData = v.swap; opCmpData = v.cmp;
    legal = (len == 8 && off % 8 == 0) || (len == 4 && off % 4 == 0);
    if (legal) begin
      prev  = mdlRead(off, len);
      match = (len == 8) ? (prev == v.cmp) : (prev[31:0] == v.cmp[31:0]);
      if (!v.cond || match)
        for (int k = 0; k < len; k++) mdl[off + k] = v.swap[8*k +: 8];
    end
    @(negedge clk);
    chk(req, "done", {63'b0, done}, 64'd1);
    chk(req, "err", {63'b0, err}, {63'b0, v.expErr});
    chk(req, "oldData", oldData, v.expOld);
    chkLine(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; opValid = 1'b0; opOffset = '0; opSize = '0; opCond = 1'b0;
    opSwapData = '0; opCmpData = '0;
    for (int n = 0; n < 64; n++) mdl[n] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "done", {63'b0, done}, 64'd0);
    chk("R1", "err", {63'b0, err}, 64'd0);
    chk("R1", "oldData", oldData, 64'd0);
    chkLine("R1");

    for (int i = 0; i < NVEC; i++) begin
      doOp(VEC[i], $sformatf("R3-R9 vector %0d", i));
      opValid = 1'b0;
      @(negedge clk);
      // R2: no done and no line change on an idle cycle
      chk("R2", "idle done", {63'b0, done}, 64'd0);
      chkLine("R9 idle");
    end

    // R10: back-to-back ops to offset 16
    doOp('{6'd16, 4'd8, 1'b0, 64'hA5A5A5A5C3C3C3C3, 64'h0, 64'h0, 1'b0}, "R10 first");
    doOp('{6'd16, 4'd8, 1'b1, 64'h0F0F0F0F0F0F0F0F, 64'hA5A5A5A5C3C3C3C3,
           64'hA5A5A5A5C3C3C3C3, 1'b0}, "R10 second");
    doOp('{6'd16, 4'd4, 1'b1, 64'h0, 64'h000000000F0F0F0F,
           64'h000000000F0F0F0F, 1'b0}, "R10 third");
    opValid = 1'b0;
    @(negedge clk);
    chk("R2", "idle done after chain", {63'b0, done}, 64'd0);
    chk("R10", "final word", lineOut[16*8 +: 64], 64'h0F0F0F0F00000000);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule